// File: doc/BRIEF.md
# Interprocessor Mailbox with Receive Interrupt

This block is a memory-mapped message channel between processors. Any number of senders push words into one first-in first-out queue through a small register window. A single receiver pulls the words out in the order they went in. The depth of the queue is fixed when the block is built.

A receive interrupt is a level. It stays high for as long as the queue holds at least one word. Draining the queue therefore also acknowledges the interrupt, and a single one-word write is enough to signal another processor. The interrupt can be masked off by software, and the receiver then polls the status word instead.

Two built-in ownership locks are provided, one for the sending side and one for the receiving side. With them, several agents can take turns and move a multi-word message without their words interleaving. Accesses that overrun or underrun the queue are dropped and recorded in sticky flags. Reading the status word clears those flags.

Top module: `ipc_mailbox`

Register window, selected by `req_addr`:
- 0: queue data (a write enqueues, a read dequeues)
- 1: status
- 2: send lock
- 3: receive lock
- 4: control

## Requirements
- R1: Words read from address 0 come out in exactly the order they were written to address 0.
- R2: A read of address 1 returns the fill count in bits [CNT_W-1:0], empty in bit 16 and full in bit 17; all other bits are zero except the flags of R3 and R4.
- R3: A write to address 0 while the queue is full is discarded, leaves the contents unchanged, and sets a sticky overflow flag in status bit 19.
- R4: A read of address 0 while the queue is empty returns zero and sets a sticky underflow flag in status bit 18.
- R5: A read of address 1 returns the sticky flags as they stood and then clears both of them.
- R6: `irq` is high whenever the queue holds at least one word and interrupts are enabled, and it falls in the cycle after the last word is read.
- R7: Control bit 0 at address 4 enables the interrupt; it resets to 1 and reads back. When it is 0, `irq` stays low whatever the fill level.
- R8: Writing a nonzero ID to a lock register (address 2 or 3) while that lock reads zero makes the lock read back that ID; any nonzero write while the lock is held leaves it unchanged.
- R9: Writing zero to a held lock frees it only when `req_id` equals the stored owner ID; a zero write from any other requester leaves it unchanged.
- R10: The send lock and the receive lock are independent: writes to one never change the other.
- R11: After reset the queue is empty, the count and both flags are zero, both locks read zero, and `irq` is low.
- R12: Every read request is answered in the next cycle with `rsp_valid` high and the data on `rsp_rdata`; writes raise no `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register select |
| req_wdata | input | DATA_W | Write data |
| req_id | input | ID_W | Requester ID, used for lock release |
| rsp_valid | output | 1 | Read data valid (cycle after read request) |
| rsp_rdata | output | DATA_W | Read data |
| irq | output | 1 | Receive interrupt level |

## Verification
The bench builds the block with DEPTH=4 and ID_W=4. A shallow queue means random traffic reaches full and empty every few dozen accesses, so overflow, underflow and the falling edge of the interrupt occur many times. A 4-bit ID space makes random lock writes often hit a zero ID, an owner match and a non-owner release attempt. DATA_W stays at 32 so that every status bit position can be seen.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] A_TXLK = 3'd2;
  localparam logic [ADDR_W-1:0] A_RXLK = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd4;

  localparam int ST_EMPTY = 16;
  localparam int ST_FULL  = 17;
  localparam int ST_UDF   = 18;
  localparam int ST_OVF   = 19;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] din,
  input  logic              pop,
  output logic [DATA_W-1:0] dout,
  output logic [CNT_W-1:0]  count,
  output logic              empty,
  output logic              full
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              push_ok, pop_ok;

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst)       dout <= '0;
    else if (pop)  dout <= pop_ok ? mem[rd_ptr] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end

  AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> (count == $past(count))); // R3
  AST_EMPTY_POP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push) |=> (dout == '0 && count == '0)); // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (push && !full && !pop) |=> (count == $past(count) + 1'b1)); // R2
endmodule

// File: rtl/mbx_lock.sv
module mbx_lock #(
  parameter int ID_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [ID_W-1:0] wr_id,
  input  logic [ID_W-1:0] req_id,
  output logic [ID_W-1:0] owner
);
  always_ff @(posedge clk) begin
    if (rst) owner <= '0;
    else if (wr_en) begin
      if (owner == '0 && wr_id != '0)      owner <= wr_id;
      else if (wr_id == '0 && req_id == owner) owner <= '0;
    end
  end

  AST_HELD_STAYS: assert property (@(posedge clk) disable iff (rst)
    (owner != '0 && wr_id != '0) |=> (owner == $past(owner))); // R8
  AST_FOREIGN_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && owner != '0 && req_id != owner) |=> (owner == $past(owner))); // R9
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import mbx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int ID_W   = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [ID_W-1:0]   req_id,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              irq
);
  logic              wr, rd, push, pop, stat_rd;
  logic [DATA_W-1:0] fifo_dout;
  logic [CNT_W-1:0]  count;
  logic              empty, full;
  logic              ovf, udf, irq_en;
  logic [1:0][ID_W-1:0] lock_owner;
  logic [DATA_W-1:0] status_word, reg_val, rsp_reg;
  logic              rsp_from_fifo;

  assign wr      = req_valid && req_write;
  assign rd      = req_valid && !req_write;
  assign push    = wr && req_addr == A_DATA;
  assign pop     = rd && req_addr == A_DATA;
  assign stat_rd = rd && req_addr == A_STAT;

  mbx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .din(req_wdata), .pop(pop),
    .dout(fifo_dout), .count(count), .empty(empty), .full(full)
  );

  for (genvar g = 0; g < 2; g++) begin : g_lock
    localparam logic [ADDR_W-1:0] LK_ADDR = (g == 0) ? A_TXLK : A_RXLK;
    mbx_lock #(.ID_W(ID_W)) u_lock (
      .clk(clk), .rst(rst), .wr_en(wr && req_addr == LK_ADDR),
      .wr_id(req_wdata[ID_W-1:0]), .req_id(req_id), .owner(lock_owner[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf    <= 1'b0;
      udf    <= 1'b0;
      irq_en <= 1'b1;
    end else begin
      if (stat_rd) begin
        ovf <= 1'b0;
        udf <= 1'b0;
      end
      if (push && full)  ovf <= 1'b1;
      if (pop && empty)  udf <= 1'b1;
      if (wr && req_addr == A_CTRL) irq_en <= req_wdata[0];
    end
  end

  always_comb begin
    status_word           = '0;
    status_word[CNT_W-1:0] = count;
    status_word[ST_EMPTY] = empty;
    status_word[ST_FULL]  = full;
    status_word[ST_UDF]   = udf;
    status_word[ST_OVF]   = ovf;
    unique case (req_addr)
      A_STAT:  reg_val = status_word;
      A_TXLK:  reg_val = DATA_W'(lock_owner[0]);
      A_RXLK:  reg_val = DATA_W'(lock_owner[1]);
      A_CTRL:  reg_val = DATA_W'(irq_en);
      default: reg_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid     <= 1'b0;
      rsp_reg       <= '0;
      rsp_from_fifo <= 1'b0;
    end else begin
      rsp_valid     <= rd;
      rsp_from_fifo <= pop;
      if (rd) rsp_reg <= reg_val;
    end
  end

  assign rsp_rdata = rsp_from_fifo ? fifo_dout : rsp_reg;
  assign irq       = irq_en && !empty;

  AST_STICKY_OVF: assert property (@(posedge clk) disable iff (rst)
    (ovf && !stat_rd) |=> ovf); // R5
  AST_STAT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (stat_rd) |=> (!ovf && !udf)); // R5
  AST_IRQ_FALLS: assert property (@(posedge clk) disable iff (rst)
    (pop && count == CNT_W'(1)) |=> !irq); // R6
  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (rst)
    rd |=> rsp_valid); // R12
  AST_LOCKS_APART: assert property (@(posedge clk) disable iff (rst)
    (wr && req_addr == A_TXLK) |=> (lock_owner[1] == $past(lock_owner[1]))); // R10
endmodule

// File: tb/ipc_mailbox_tb.sv
module ipc_mailbox_tb;
  localparam int DW = 32, DEPTH = 4, IDW = 4;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0;
  logic [2:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [IDW-1:0] req_id = '0;
  logic rsp_valid, irq;
  logic [DW-1:0] rsp_rdata;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [DW-1:0] q[$];
  bit m_ovf, m_udf, m_ien;
  logic [IDW-1:0] m_lk [2];

  ipc_mailbox #(.DATA_W(DW), .DEPTH(DEPTH), .ID_W(IDW)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_id(req_id),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq));

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_status();
    logic [DW-1:0] s = '0;
    s[2:0] = 3'(q.size());
    s[16]  = (q.size() == 0);
    s[17]  = (q.size() == DEPTH);
    s[18]  = m_udf;
    s[19]  = m_ovf;
    return s;
  endfunction

  task automatic bus(input logic w, input logic [2:0] a, input logic [DW-1:0] d,
                     input logic [IDW-1:0] id, output logic [DW-1:0] r);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d; req_id = id;
    @(posedge clk);
    #1;
    req_valid = 0;
    chk("R12 rsp_valid", DW'(rsp_valid), DW'(!w));
    r = rsp_rdata;
  endtask

  task automatic m_write(input logic [2:0] a, input logic [DW-1:0] d, input logic [IDW-1:0] id);
    logic [DW-1:0] r;
    bus(1, a, d, id, r);
    case (a)
      3'd0: if (q.size() < DEPTH) q.push_back(d); else m_ovf = 1;
      3'd2, 3'd3: begin
        int k = (a == 3'd2) ? 0 : 1;
        if (m_lk[k] == 0 && d[IDW-1:0] != 0) m_lk[k] = d[IDW-1:0];
        else if (d[IDW-1:0] == 0 && id == m_lk[k]) m_lk[k] = 0;
      end
      3'd4: m_ien = d[0];
      default: ;
    endcase
    chk("R6/R7 irq", DW'(irq), DW'(m_ien && q.size() != 0));
  endtask

  task automatic m_read(input logic [2:0] a, input logic [IDW-1:0] id);
    logic [DW-1:0] r, e;
    bus(0, a, '0, id, r);
    case (a)
      3'd0: begin
        if (q.size() != 0) e = q.pop_front(); else begin e = '0; m_udf = 1; end
        chk("R1/R4 data", r, e);
      end
      3'd1: begin e = exp_status(); chk("R2/R5 status", r, e); m_ovf = 0; m_udf = 0; end
      3'd2: chk("R8/R9 send lock", r, DW'(m_lk[0]));
      3'd3: chk("R8/R10 recv lock", r, DW'(m_lk[1]));
      3'd4: chk("R7 ctrl", r, DW'(m_ien));
      default: chk("R12 unused", r, '0);
    endcase
    chk("R6/R7 irq", DW'(irq), DW'(m_ien && q.size() != 0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_ien = 1; m_lk[0] = 0; m_lk[1] = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    chk("R11 irq after reset", DW'(irq), '0);
    m_read(3'd1, 0);   // R11 status reset
    m_read(3'd2, 0);
    m_read(3'd3, 0);
    m_read(3'd4, 0);   // R7 reset value 1
    // R6 single-word signal then drain
    m_write(3'd0, 32'hA5A5_0001, 1);
    m_read(3'd0, 1);
    // R3 fill past full
    for (int i = 0; i < DEPTH + 2; i++) m_write(3'd0, 32'h100 + i, 2);
    m_read(3'd1, 0);   // R3 overflow, R2 full
    m_read(3'd1, 0);   // R5 cleared
    for (int i = 0; i < DEPTH + 1; i++) m_read(3'd0, 0);  // R1 order, R4 underflow
    m_read(3'd1, 0);
    // R7 masked irq
    m_write(3'd4, 0, 0);
    m_write(3'd0, 32'h77, 0);
    m_write(3'd4, 1, 0);
    m_read(3'd0, 0);
    // R8 R9 R10 locks
    m_write(3'd2, 5, 5);
    m_write(3'd2, 6, 6);
    m_read(3'd2, 0);
    m_write(3'd2, 0, 6);
    m_read(3'd2, 0);
    m_read(3'd3, 0);
    m_write(3'd3, 9, 9);
    m_write(3'd2, 0, 5);
    m_read(3'd2, 0);
    m_read(3'd3, 0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int sel = int'($urandom_range(0, 99));
      logic [IDW-1:0] id = IDW'($urandom);
      logic [DW-1:0] d = $urandom;
      if (sel < 38)      m_write(3'd0, d, id);
      else if (sel < 68) m_read(3'd0, id);
      else if (sel < 76) m_read(3'd1, id);
      else if (sel < 84) m_write(3'($urandom_range(2, 3)), (sel < 80) ? DW'(id) : '0, id);
      else if (sel < 92) m_read(3'($urandom_range(2, 7)), id);
      else               m_write(3'd4, DW'($urandom_range(0, 1)), id);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule